// File: doc/BRIEF.md
# Edge-Detect Interrupt Bank for General-Purpose Inputs

This block watches a bank of general-purpose input pins driven by external devices that run on their own clocks, and raises one interrupt when a selected edge turns up on any pin. Each pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with its value one cycle earlier. A 2-bit mode field per pin chooses which edges count. A 2-bit sticky status field per pin records which enabled edge kinds have happened since software last read it.

Software uses a small register port with one select bit. Select 0 is the mode register and select 1 is the status register. Pin n owns bits [2n+1:2n] of both. Read data is registered and is valid in the cycle after the read strobe. A read of the status register returns the current status and clears the whole register in the same edge, which completes servicing. An enabled edge that lands on the clearing edge is kept as fresh status. Each pin's status is a four-state machine: PS_QUIET (00), PS_ROSE (01), PS_FELL (10) and PS_GLITCH (11). Its transitions are QUIET→ROSE on a rise hit, QUIET→FELL on a fall hit, ROSE→GLITCH on a fall hit, FELL→GLITCH on a rise hit, and any state→QUIET on a status read. When the status read and a hit come together, the machine starts from QUIET and takes the hit's transition. The interrupt output is a registered OR of every status bit.

Top module: `edge_irq_bank`

## Requirements
- R1: After reset the mode register, the status register, reg_rdata_o and irq_o are all zero.
- R2: A write with reg_sel_i=0 loads reg_wdata_i into the mode register. A read with reg_sel_i=0 returns it on reg_rdata_o one cycle later, and pin n's mode is bits [2n+1:2n].
- R3: In mode 01, a rising edge on a pin sets status bit 2n (field 01) and a falling edge is ignored. The bit appears three clock edges after the pin is first sampled high, and it stays set until a status read.
- R4: In mode 10, a falling edge sets status bit 2n+1 (field 10) and a rising edge is ignored.
- R5: In mode 11, either edge is recorded. Both edges between two status reads give field 11 (glitch).
- R6: In mode 00, a pin never sets status bits.
- R7: A read with reg_sel_i=1 returns the status register one cycle later and clears all of it at the same edge. A mode read clears nothing.
- R8: An enabled edge detected on the same clock edge as a status read is kept as newly set status. The read returns the status from before that edge.
- R9: irq_o is the OR of all status bits, registered, so it follows status by one cycle.
- R10: Writes with reg_sel_i=1 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous input pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | 0 selects the mode register, 1 selects the status register |
| reg_wdata_i | input | 2*NUM_PINS | Write data |
| reg_rdata_o | output | 2*NUM_PINS | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
A pin state machine stuck in or leaping to a wrong state shows up in the next status read as a wrong 2-bit field. It also shows on irq_o one cycle after the bad transition, as a raised or missing interrupt. A clear that drops a coinciding edge, or that fails to clear, is caught by reading status twice back to back. The second read is visible two cycles after the first strobe. Wrong edge enables show up three edges after a pin toggle as status bits set on pins that should stay quiet.

// File: rtl/eib_pkg.sv
package eib_pkg;
    typedef enum logic [1:0] {
        PS_QUIET  = 2'b00,
        PS_ROSE   = 2'b01,
        PS_FELL   = 2'b10,
        PS_GLITCH = 2'b11
    } pin_st_e;

    localparam logic SEL_MODE   = 1'b0;
    localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/eib_edge_det.sv
module eib_edge_det #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // two-flop synchroniser followed by a history flop
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise_o = sync_q & ~prev_q;
        fall_o = ~sync_q & prev_q;
    end
endmodule

// File: rtl/eib_pin_fsm.sv
module eib_pin_fsm
    import eib_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       clr_i,
    output logic [1:0] status_o
);
    pin_st_e state_q;
    pin_st_e state_d;
    pin_st_e base;
    logic    hit_r;
    logic    hit_f;

    always_comb begin
        hit_r = rise_i & mode_i[0];
        hit_f = fall_i & mode_i[1];
        // a status read restarts from quiet; a hit in the same cycle survives
        base  = clr_i ? PS_QUIET : state_q;
        state_d = base;
        unique case (base)
            PS_QUIET: begin
                if (hit_r)      state_d = PS_ROSE;
                else if (hit_f) state_d = PS_FELL;
            end
            PS_ROSE: begin
                if (hit_f)      state_d = PS_GLITCH;
            end
            PS_FELL: begin
                if (hit_r)      state_d = PS_GLITCH;
            end
            PS_GLITCH: begin
                state_d = PS_GLITCH;
            end
            default: state_d = PS_QUIET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PS_QUIET;
        else         state_q <= state_d;
    end

    always_comb begin
        status_o = state_q;
    end
endmodule

// File: rtl/eib_regport.sv
module eib_regport
    import eib_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          sel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] status_i,
    output logic [DW-1:0] mode_o,
    output logic          clr_o,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mode_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= '0;
        end else if (wr_i && sel_i == SEL_MODE) begin
            mode_q <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= (sel_i == SEL_STATUS) ? status_i : mode_q;
        end
    end

    always_comb begin
        clr_o   = rd_i && (sel_i == SEL_STATUS);
        mode_o  = mode_q;
        rdata_o = rdata_q;
    end
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
    parameter int NUM_PINS = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_sel_i,
    input  logic [2*NUM_PINS-1:0] reg_wdata_i,
    output logic [2*NUM_PINS-1:0] reg_rdata_o,
    output logic                  irq_o
);
    localparam int DW = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] rise_w;
    logic [NUM_PINS-1:0] fall_w;
    logic [DW-1:0]       mode_w;
    logic [DW-1:0]       status_w;
    logic                clr_w;
    logic                irq_q;

    eib_edge_det #(.WIDTH(NUM_PINS)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pins_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    eib_regport #(.DW(DW)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .status_i(status_w),
        .mode_o  (mode_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata_o)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        eib_pin_fsm u_fsm (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .mode_i  (mode_w[2*n+1:2*n]),
            .rise_i  (rise_w[n]),
            .fall_i  (fall_w[n]),
            .clr_i   (clr_w),
            .status_o(status_w[2*n+1:2*n])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= |status_w;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/eib_chk.sv
module eib_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  reg_wr_i,
    input logic                  reg_rd_i,
    input logic                  reg_sel_i,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic [2*NUM_PINS-1:0] status_q,
    input logic                  irq_o
);
    logic rd_status;
    assign rd_status = reg_rd_i && reg_sel_i;

    AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|status_q))); // R9

    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_status && mode_q == '0) |=> (status_q == '0)); // R7

    AST_STATUS_WR_NO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_sel_i) |=> $stable(mode_q)); // R10

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
        AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_q[2*n] && !rd_status) |=> status_q[2*n]); // R3
        AST_STICKY_HOLD_F: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_q[2*n+1] && !rd_status) |=> status_q[2*n+1]); // R4
        AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_q[2*n+1:2*n] == 2'b00 && status_q[2*n+1:2*n] == 2'b00)
            |=> (status_q[2*n+1:2*n] == 2'b00)); // R6
    end
endmodule

bind edge_irq_bank eib_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reg_wr_i (reg_wr_i),
    .reg_rd_i (reg_rd_i),
    .reg_sel_i(reg_sel_i),
    .mode_q   (mode_w),
    .status_q (status_w),
    .irq_o    (irq_o)
);

// File: tb/edge_irq_bank_tb.sv
module edge_irq_bank_tb;
    localparam int N  = 16;
    localparam int DW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic          sel = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          pend = 1'b0;

    always #4 clk = ~clk;

    edge_irq_bank #(.NUM_PINS(N)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pins_i     (pins),
        .reg_wr_i   (wr),
        .reg_rd_i   (rd),
        .reg_sel_i  (sel),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .irq_o      (irq)
    );

    // monitor: a read strobe taken at a posedge yields data checked at the next negedge
    always @(posedge clk) pend <= rd;

    always @(negedge clk) begin
        if (pend) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s read data: actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(logic s, logic [DW-1:0] v);
        wr = 1'b1; sel = s; wdata = v;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    // driver: issues the read now and pushes the expected value
    task automatic read_reg(logic s, logic [DW-1:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1; sel = s;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic check_irq(logic e, string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq: actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check_irq(1'b0, "R1");
        read_reg(1'b0, 32'h0, "R1 mode");
        read_reg(1'b1, 32'h0, "R1 status");

        // R2: pin0=01 rise, pin1=10 fall, pin2=11 both, pin3=00 off
        write_reg(1'b0, 32'h0000_0039);
        read_reg(1'b0, 32'h0000_0039, "R2 mode");
        read_reg(1'b0, 32'h0000_0039, "R2 mode reread");

        // rises on pins 0, 1, 3
        pins[0] = 1'b1; pins[1] = 1'b1; pins[3] = 1'b1;
        step(5);
        check_irq(1'b1, "R9 raised");
        read_reg(1'b0, 32'h0000_0039, "R7 mode read leaves status");
        read_reg(1'b1, 32'h0000_0001, "R3 rise pin0, R4 pin1 ignores rise, R6 pin3");
        read_reg(1'b1, 32'h0, "R7 cleared");
        step(1);
        check_irq(1'b0, "R9 dropped");

        // falls on pins 0, 1, 3
        pins[0] = 1'b0; pins[1] = 1'b0; pins[3] = 1'b0;
        step(5);
        read_reg(1'b1, 32'h0000_0008, "R4 fall pin1, R3 pin0 ignores fall");

        // glitch on pin2
        pins[2] = 1'b1;
        step(2);
        pins[2] = 1'b0;
        step(5);
        read_reg(1'b1, 32'h0000_0030, "R5 glitch pin2");

        // R10: write to status select
        pins[2] = 1'b1;
        step(5);
        write_reg(1'b1, '1);
        read_reg(1'b0, 32'h0000_0039, "R10 mode kept");
        read_reg(1'b1, 32'h0000_0010, "R10 status kept / R5 rise pin2");

        // R8: fall on pin2 detected on the same edge as a status read
        pins[2] = 1'b0;
        step(2);
        read_reg(1'b1, 32'h0, "R8 read returns pre-edge status");
        read_reg(1'b1, 32'h0000_0020, "R8 coinciding edge kept");

        // R6: all modes off
        write_reg(1'b0, 32'h0);
        pins = '1;
        step(5);
        pins = '0;
        step(5);
        check_irq(1'b0, "R6 no irq");
        read_reg(1'b1, 32'h0, "R6 no status");

        step(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule